// File: doc/BRIEF.md
# Stack Pointer Select and Limit Guard

This block keeps the two stack pointers of a hart (a main pointer and a thread pointer) and one lower bound for each, all reachable through a small control-register port. From the current hart mode and a thread-stack enable input it presents the stack pointer that is active now. The main pointer is the default, and handler code always runs on it.

Every stack write request is checked in the same cycle against the lower bound of the stack it targets. Stores that build an interrupt or exception frame always target the main stack, whatever the mode. When the address lies below the bound, the block withholds the grant and raises a one-cycle fault, so the write never reaches memory. A build parameter removes the bound registers for small configurations. In that case they read as zero and no write is ever rejected.

Top module: `stack_guard_top`

## Requirements
- R1: After reset the active pointer output equals the main pointer's startup value (default 0x2000_1000), and the main bound reads its startup value (default 0x2000_0000).
- R2: With the thread-stack enable at 0 the active pointer is always the main pointer. With it at 1 and the hart in application mode (handler input 0), the active pointer is the thread pointer.
- R3: With the handler input at 1 the active pointer is the main pointer, whatever the thread-stack enable.
- R4: A stack write flagged as a frame store is checked against the main bound even while the thread stack is active.
- R5: Bit 0 of every pointer and bound register reads as 0, and a control-register write to bit 0 has no effect.
- R6: A stack write whose address is below the bound of its stack raises the fault output and drops the grant, in the same cycle as the request only.
- R7: The comparison is unsigned, and an address equal to the bound is granted.
- R8: A bound of zero lets every address through.
- R9: With the bound registers left out (HAS_LIMITS=0), both bound selects read 0, writes to them are ignored, and no stack write faults.
- R10: A control-register write changes only the selected register, and the new value reads back from the next cycle on. The select codes are 0 main pointer, 1 main bound, 2 thread pointer, 3 thread bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 2 | Register select: 0 main pointer, 1 main bound, 2 thread pointer, 3 thread bound |
| csr_we | input | 1 | Write enable for the selected register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register |
| thr_stack_en | input | 1 | Thread-stack enable |
| in_handler | input | 1 | Hart is running handler code |
| frame_store | input | 1 | Current stack write belongs to an exception or interrupt frame |
| st_req | input | 1 | Stack write request |
| st_addr | input | XLEN | Stack write address |
| sp_active | output | XLEN | Active stack pointer |
| st_grant | output | 1 | Stack write may proceed |
| st_fault | output | 1 | Stack write rejected by the bound check |

## Verification
A corrupted pointer or bound register shows up at the ports the moment it is selected for read-back, or on the next stack write that compares against it. The grant and fault outputs react combinationally, so a wrong bound changes them in the same cycle as the request. A wrong mode decode shows at once on the active pointer output. Frame stores made while the thread stack is active show whether the bound is taken from the wrong stack.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        CSR_MAIN_SP  = 2'd0,
        CSR_MAIN_LIM = 2'd1,
        CSR_THR_SP   = 2'd2,
        CSR_THR_LIM  = 2'd3
    } csr_sel_e;

    typedef enum logic {
        STK_MAIN   = 1'b0,
        STK_THREAD = 1'b1
    } stack_id_e;

endpackage

// File: rtl/spg_regfile.sv
module spg_regfile
    import spg_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter bit          HAS_LIMITS    = 1'b1,
    parameter logic [XLEN-1:0] MAIN_SP_INIT  = 32'h2000_1000,
    parameter logic [XLEN-1:0] MAIN_LIM_INIT = 32'h2000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  csr_sel_e        csr_sel,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] main_sp,
    output logic [XLEN-1:0] main_lim,
    output logic [XLEN-1:0] thr_sp,
    output logic [XLEN-1:0] thr_lim
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [XLEN-1:0] main_sp;
        logic [XLEN-1:0] main_lim;
        logic [XLEN-1:0] thr_sp;
        logic [XLEN-1:0] thr_lim;
    } regs_t;

    regs_t           regs_d, regs_q;
    logic [XLEN-1:0] wval;

    always_comb begin
        regs_d = regs_q;
        wval   = csr_wdata & ALIGN_MASK;
        if (csr_we) begin
            unique case (csr_sel)
                CSR_MAIN_SP:  regs_d.main_sp  = wval;
                CSR_MAIN_LIM: regs_d.main_lim = wval;
                CSR_THR_SP:   regs_d.thr_sp   = wval;
                CSR_THR_LIM:  regs_d.thr_lim  = wval;
                default:      regs_d = regs_q;
            endcase
        end
    end

    // Thread registers have no defined reset value by contract; they are
    // cleared here only to keep simulation free of unknowns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.main_sp  <= MAIN_SP_INIT & ALIGN_MASK;
            regs_q.main_lim <= MAIN_LIM_INIT & ALIGN_MASK;
            regs_q.thr_sp   <= '0;
            regs_q.thr_lim  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign main_sp = regs_q.main_sp;
    assign thr_sp  = regs_q.thr_sp;

    generate
        if (HAS_LIMITS) begin : g_limits
            assign main_lim = regs_q.main_lim;
            assign thr_lim  = regs_q.thr_lim;
        end else begin : g_no_limits
            logic [2*XLEN-1:0] unused_lim;
            assign unused_lim = {regs_q.main_lim, regs_q.thr_lim};
            assign main_lim   = '0;
            assign thr_lim    = '0;
        end
    endgenerate

    always_comb begin
        unique case (csr_sel)
            CSR_MAIN_SP:  csr_rdata = main_sp;
            CSR_MAIN_LIM: csr_rdata = main_lim;
            CSR_THR_SP:   csr_rdata = thr_sp;
            CSR_THR_LIM:  csr_rdata = thr_lim;
            default:      csr_rdata = '0;
        endcase
    end

    // R10: a write to the main pointer is visible in the following cycle
    p_main_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == CSR_MAIN_SP) |=>
            (regs_q.main_sp == {$past(csr_wdata[XLEN-1:1]), 1'b0}));

    // R10: a write elsewhere leaves the thread pointer untouched
    p_thr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel != CSR_THR_SP) |=> $stable(regs_q.thr_sp));

endmodule

// File: rtl/spg_select.sv
module spg_select
    import spg_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            thr_stack_en,
    input  logic            in_handler,
    input  logic [XLEN-1:0] main_sp,
    input  logic [XLEN-1:0] thr_sp,
    output stack_id_e       active_id,
    output logic [XLEN-1:0] sp_active
);

    always_comb begin
        active_id = STK_MAIN;
        if (thr_stack_en && !in_handler) begin
            active_id = STK_THREAD;
        end
    end

    generate
        for (genvar b = 0; b < XLEN; b++) begin : g_mux
            assign sp_active[b] = (active_id == STK_THREAD) ? thr_sp[b] : main_sp[b];
        end
    endgenerate

    // R3: handler code always runs on the main pointer
    p_handler_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> (sp_active == main_sp));

    // R2: thread stack disabled means main pointer
    p_disabled_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_stack_en |-> (sp_active == main_sp));

endmodule

// File: rtl/spg_limit_check.sv
module spg_limit_check
    import spg_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_req,
    input  logic [XLEN-1:0] st_addr,
    input  logic            frame_store,
    input  stack_id_e       active_id,
    input  logic [XLEN-1:0] main_lim,
    input  logic [XLEN-1:0] thr_lim,
    output logic            st_grant,
    output logic            st_fault
);

    stack_id_e       check_id;
    logic [XLEN-1:0] bound;
    logic            below;

    always_comb begin
        check_id = frame_store ? STK_MAIN : active_id;
        bound    = (check_id == STK_THREAD) ? thr_lim : main_lim;
        below    = st_addr < bound;
        st_fault = st_req && below;
        st_grant = st_req && !below;
    end

    // R6: grant and fault never together
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_grant && st_fault));

    // R6: fault only with a request
    p_fault_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> st_req);

    // R6: every request is answered by exactly one of grant or fault
    p_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_grant || st_fault));

    // R4: a frame store at or above the main bound is never rejected
    p_frame_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && frame_store && st_addr >= main_lim) |-> !st_fault);

endmodule

// File: rtl/stack_guard_top.sv
module stack_guard_top
    import spg_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter bit          HAS_LIMITS    = 1'b1,
    parameter logic [XLEN-1:0] MAIN_SP_INIT  = 32'h2000_1000,
    parameter logic [XLEN-1:0] MAIN_LIM_INIT = 32'h2000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      csr_sel,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            thr_stack_en,
    input  logic            in_handler,
    input  logic            frame_store,
    input  logic            st_req,
    input  logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] sp_active,
    output logic            st_grant,
    output logic            st_fault
);

    logic [XLEN-1:0] main_sp_w, main_lim_w, thr_sp_w, thr_lim_w;
    stack_id_e       active_id_w;
    csr_sel_e        sel_w;

    assign sel_w = csr_sel_e'(csr_sel);

    spg_regfile #(
        .XLEN          (XLEN),
        .HAS_LIMITS    (HAS_LIMITS),
        .MAIN_SP_INIT  (MAIN_SP_INIT),
        .MAIN_LIM_INIT (MAIN_LIM_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_sel   (sel_w),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .main_sp   (main_sp_w),
        .main_lim  (main_lim_w),
        .thr_sp    (thr_sp_w),
        .thr_lim   (thr_lim_w)
    );

    spg_select #(.XLEN(XLEN)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_stack_en (thr_stack_en),
        .in_handler   (in_handler),
        .main_sp      (main_sp_w),
        .thr_sp       (thr_sp_w),
        .active_id    (active_id_w),
        .sp_active    (sp_active)
    );

    spg_limit_check #(.XLEN(XLEN)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_req      (st_req),
        .st_addr     (st_addr),
        .frame_store (frame_store),
        .active_id   (active_id_w),
        .main_lim    (main_lim_w),
        .thr_lim     (thr_lim_w),
        .st_grant    (st_grant),
        .st_fault    (st_fault)
    );

    // R5: bit 0 of the read port and the active pointer stays clear
    p_bit0_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[0] == 1'b0) && (sp_active[0] == 1'b0));

endmodule

// File: tb/tb_stack_guard_top.sv
module tb_stack_guard_top;

    localparam int unsigned XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            thr_stack_en = 1'b0;
    logic            in_handler = 1'b0;
    logic            frame_store = 1'b0;
    logic            st_req = 1'b0;
    logic [XLEN-1:0] st_addr = '0;

    logic [XLEN-1:0] csr_rdata, sp_active, nl_rdata, nl_sp;
    logic            st_grant, st_fault, nl_grant, nl_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stack_guard_top dut (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .thr_stack_en(thr_stack_en), .in_handler(in_handler),
        .frame_store(frame_store), .st_req(st_req), .st_addr(st_addr),
        .sp_active(sp_active), .st_grant(st_grant), .st_fault(st_fault)
    );

    stack_guard_top #(.HAS_LIMITS(1'b0)) dut_nl (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(nl_rdata),
        .thr_stack_en(thr_stack_en), .in_handler(in_handler),
        .frame_store(frame_store), .st_req(st_req), .st_addr(st_addr),
        .sp_active(nl_sp), .st_grant(nl_grant), .st_fault(nl_fault)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [XLEN-1:0] val);
        @(negedge clk);
        csr_sel = sel; csr_wdata = val; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] sel, output logic [XLEN-1:0] val);
        csr_sel = sel;
        #1;
        val = csr_rdata;
    endtask

    task automatic stk(input logic [XLEN-1:0] addr, input logic frame,
                       output logic g, output logic f);
        @(negedge clk);
        st_addr = addr; frame_store = frame; st_req = 1'b1;
        #1;
        g = st_grant; f = st_fault;
        @(negedge clk);
        st_req = 1'b0; frame_store = 1'b0;
    endtask

    task automatic t_reset();
        logic [XLEN-1:0] v;
        check("R1 active sp", sp_active, 32'h2000_1000);
        csr_rd(2'd1, v);
        check("R1 main bound", v, 32'h2000_0000);
        csr_rd(2'd0, v);
        check("R1 main sp", v, 32'h2000_1000);
    endtask

    task automatic t_csr();
        logic [XLEN-1:0] v;
        csr_wr(2'd2, 32'h3000_0FFF);
        csr_rd(2'd2, v);
        check("R5 thread sp bit0 dropped", v, 32'h3000_0FFE);
        csr_rd(2'd0, v);
        check("R10 main sp untouched", v, 32'h2000_1000);
        csr_wr(2'd3, 32'h3000_0001);
        csr_rd(2'd3, v);
        check("R5 thread bound bit0 dropped", v, 32'h3000_0000);
        csr_rd(2'd2, v);
        check("R10 thread sp untouched", v, 32'h3000_0FFE);
    endtask

    task automatic t_select();
        @(negedge clk);
        thr_stack_en = 1'b0; in_handler = 1'b0;
        #1;
        check("R2 disabled uses main", sp_active, 32'h2000_1000);
        thr_stack_en = 1'b1;
        #1;
        check("R2 app mode uses thread", sp_active, 32'h3000_0FFE);
    endtask

    task automatic t_handler();
        @(negedge clk);
        thr_stack_en = 1'b1; in_handler = 1'b1;
        #1;
        check("R3 handler uses main", sp_active, 32'h2000_1000);
        in_handler = 1'b0;
        #1;
        check("R3 back to thread", sp_active, 32'h3000_0FFE);
    endtask

    task automatic t_bound();
        logic g, f;
        stk(32'h2FFF_FFFC, 1'b0, g, f);
        check("R6 below bound fault", {31'd0, f}, 1);
        check("R6 below bound no grant", {31'd0, g}, 0);
        #1;
        check("R6 fault single cycle", {31'd0, st_fault}, 0);
        stk(32'h3000_0000, 1'b0, g, f);
        check("R7 equal granted", {30'd0, g, f}, 2'b10);
        stk(32'h8000_0000, 1'b0, g, f);
        check("R7 unsigned high address", {30'd0, g, f}, 2'b10);
    endtask

    task automatic t_frame();
        logic g, f;
        stk(32'h2FFF_FFFC, 1'b1, g, f);
        check("R4 frame uses main bound", {30'd0, g, f}, 2'b10);
        stk(32'h1FFF_FFF0, 1'b1, g, f);
        check("R4 frame below main bound", {30'd0, g, f}, 2'b01);
    endtask

    task automatic t_zero();
        logic g, f;
        csr_wr(2'd3, 32'h0);
        stk(32'h0, 1'b0, g, f);
        check("R8 zero bound grants", {30'd0, g, f}, 2'b10);
    endtask

    task automatic t_nolimit();
        logic g, f;
        csr_wr(2'd1, 32'h0000_1000);
        csr_sel = 2'd1;
        #1;
        check("R9 absent bound reads 0", nl_rdata, 32'h0);
        check("R9 present bound written", csr_rdata, 32'h0000_1000);
        @(negedge clk);
        thr_stack_en = 1'b0;
        st_addr = 32'h10; st_req = 1'b1;
        #1;
        check("R9 no fault without bounds", {30'd0, nl_grant, nl_fault}, 2'b10);
        check("R6 with bounds faults", {30'd0, st_grant, st_fault}, 2'b01);
        @(negedge clk);
        st_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_csr();
        t_select();
        t_handler();
        t_bound();
        t_frame();
        t_zero();
        t_nolimit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule